// File: doc/BRIEF.md
# Byte-Wide Boot Loader Engine

After reset, this engine fills the on-chip instruction RAM from an external memory that is one byte wide. It can also refill the RAM at any later time when software requests it. The external memory holds 64K bytes in eight pages of 8K bytes. A 3-bit page number and a 13-bit byte offset together form each byte address. The engine lowers a select strobe and a read strobe for every byte, and holds them low for a programmable number of wait states. It reads one byte lane of the data bus.

Every three bytes are joined into one 24-bit instruction word, most significant byte first. Each word is written to the instruction RAM, starting at word 0 and counting up. The core is held in reset for the whole load. A one-cycle done pulse follows the last write.

An external master may request the bus during a load. The grant is given only at a byte boundary, and reading resumes once the request is withdrawn.

Top module: `boot_loader`

## Requirements
- R1: The byte address seen on the pins is page*8192 + offset. The offset starts at 0 for each load and rises by one for each new byte.
- R2: Byte k of the load (counting from 0) goes into word k/3. The first byte of a word lands in bits 23:16 and the third in bits 7:0. Words are written at RAM addresses 0, 1, 2 … WORDS-1, in that order, one `ram_we` pulse each.
- R3: Each byte read keeps its address and strobes steady for wait+1 cycles. The wait value runs from 0 to 7, is loaded through `cfg_wait_we`/`cfg_wait`, and is 3 after reset.
- R4: Pin mapping: `ext_addr[12:0]` carries the offset and `ext_addr[13]` carries page bit 0. `ext_dhi[1:0]` carries page bits 2:1 and is meant for the two top data-bus pins. `ext_doe` is high while a byte is read.
- R5: Each byte is taken from `ext_lane_din`, which connects to data-bus bits 15:8. It is sampled at the clock edge that ends the byte's last wait cycle.
- R6: Whether a load starts after reset depends on `map_sel` in the first cycle after reset. If it is 0, a load of page 0 starts. If it is 1, the engine stays idle: strobes stay high and the core is not held.
- R7: A one-cycle `sw_boot` pulse while idle starts a load of page `sw_page`.
- R8: `core_hold` is high during reset and for the whole load. `boot_done` pulses for one cycle, in the cycle after the final RAM write, and `core_hold` is low from that cycle on.
- R9: A bus request made during a load is granted only after the byte in progress completes. The strobes stay high while the grant is held. The next byte starts in the cycle after the request drops.
- R10: A `sw_boot` pulse during a load has no effect. The load in progress finishes with its own page, and no second load follows.
- R11: `bsel_n` and `rd_n` go low together for every byte access and high together otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_sel | input | 1 | Memory-map select; 0 enables the load after reset |
| sw_boot | input | 1 | Software request to start a load |
| sw_page | input | 3 | Page used by a software-requested load |
| cfg_wait_we | input | 1 | Load enable for the wait-state setting |
| cfg_wait | input | 3 | Wait states per byte read |
| ext_bus_req | input | 1 | External bus request |
| ext_bus_grant | output | 1 | External bus grant |
| ext_addr | output | 14 | Byte offset plus page bit 0 on the top pin |
| ext_dhi | output | 2 | Page bits 2:1, driven onto the two top data-bus pins |
| ext_doe | output | 1 | Output enable for `ext_dhi` |
| ext_lane_din | input | 8 | Data-bus bits 15:8 |
| bsel_n | output | 1 | Boot memory select, active low |
| rd_n | output | 1 | Read strobe, active low |
| ram_we | output | 1 | Instruction RAM write enable |
| ram_addr | output | 11 | Instruction RAM word address |
| ram_wdata | output | 24 | Instruction RAM write data |
| core_hold | output | 1 | Holds the core in reset while loading |
| boot_done | output | 1 | One-cycle pulse after the last word is written |

## Verification
The hardest case to reach is a bus request that arrives in the middle of a long byte read. A wrong design would then grant at once and cut the byte short. The bench sets 7 wait states and raises the request only after several bytes have begun. It then checks the length of every strobe-low run against wait+1 and confirms that the next address after the grant is the next offset. A software boot pulse is also issued during that same load, which exercises R10 while the engine is busy.

// File: rtl/bootld_pkg.sv
package bootld_pkg;
   typedef enum logic [2:0] {
      BL_RESET,
      BL_IDLE,
      BL_READ,
      BL_YIELD,
      BL_FINISH
   } bl_state_e;
endpackage

// File: rtl/bootld_wait_timer.sv
module bootld_wait_timer #(
   parameter int WAIT_W   = 3,
   parameter int WAIT_RST = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [WAIT_W-1:0] cfg_val,
   input  logic              run,
   output logic              expire
);
   logic [WAIT_W-1:0] wait_q;
   logic [WAIT_W-1:0] cnt;

   assign expire = run && (cnt >= wait_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wait_q <= WAIT_W'(WAIT_RST);
         cnt    <= '0;
      end else begin
         if (cfg_we)
            wait_q <= cfg_val;
         if (!run || expire)
            cnt <= '0;
         else
            cnt <= cnt + 1'b1;
      end
   end

   // a non-zero setting never lets two bytes finish on adjacent cycles
   AST_WAIT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && wait_q != '0 && !cfg_we) |=> !expire); // R3
endmodule

// File: rtl/bootld_addr_gen.sv
module bootld_addr_gen #(
   parameter int PAGE_W   = 3,
   parameter int OFFSET_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [PAGE_W-1:0] start_page,
   input  logic              step,
   output logic [OFFSET_W:0] ext_addr,
   output logic [PAGE_W-2:0] page_hi
);
   logic [PAGE_W-1:0]   page_q;
   logic [OFFSET_W-1:0] offset_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page_q   <= '0;
         offset_q <= '0;
      end else if (start) begin
         page_q   <= start_page;
         offset_q <= '0;
      end else if (step) begin
         offset_q <= offset_q + 1'b1;
      end
   end

   assign ext_addr = {page_q[0], offset_q};
   assign page_hi  = page_q[PAGE_W-1:1];

   // the image fits in one page, so the offset never wraps
   AST_OFFSET_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> (offset_q != '1)); // R1
endmodule

// File: rtl/bootld_packer.sv
module bootld_packer #(
   parameter int BYTE_W = 8,
   parameter int WORD_W = 24,
   parameter int WORDS  = 2048,
   localparam int NB    = WORD_W / BYTE_W,
   localparam int LW    = (NB > 1) ? $clog2(NB) : 1,
   localparam int AW    = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              byte_vld,
   input  logic [BYTE_W-1:0] byte_in,
   output logic              last_byte,
   output logic              word_we,
   output logic [AW-1:0]     word_addr,
   output logic [WORD_W-1:0] word_data
);
   logic [WORD_W-BYTE_W-1:0] sh_q;
   logic [WORD_W-BYTE_W-1:0] sh_next;
   logic [LW-1:0]            lane_q;
   logic [AW-1:0]            wcnt_q;
   logic                     lane_full;

   assign lane_full = (lane_q == LW'(NB - 1));
   assign last_byte = lane_full && (wcnt_q == AW'(WORDS - 1));

   generate
      if (NB > 2) begin : g_wide
         assign sh_next = {sh_q[WORD_W-2*BYTE_W-1:0], byte_in};
      end else begin : g_pair
         assign sh_next = byte_in;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q      <= '0;
         lane_q    <= '0;
         wcnt_q    <= '0;
         word_we   <= 1'b0;
         word_addr <= '0;
         word_data <= '0;
      end else if (clr) begin
         lane_q  <= '0;
         wcnt_q  <= '0;
         word_we <= 1'b0;
      end else begin
         word_we <= 1'b0;
         if (byte_vld) begin
            sh_q <= sh_next;
            if (lane_full) begin
               lane_q    <= '0;
               word_we   <= 1'b1;
               word_addr <= wcnt_q;
               word_data <= {sh_q, byte_in};
               wcnt_q    <= wcnt_q + 1'b1;
            end else begin
               lane_q <= lane_q + 1'b1;
            end
         end
      end
   end

   AST_WORD_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      word_we |-> $past(byte_vld)); // R2
endmodule

// File: rtl/boot_loader.sv
module boot_loader
   import bootld_pkg::*;
#(
   parameter int WORDS    = 2048,
   parameter int PAGE_W   = 3,
   parameter int OFFSET_W = 13,
   parameter int BYTE_W   = 8,
   parameter int WORD_W   = 24,
   parameter int WAIT_W   = 3,
   parameter int WAIT_RST = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     map_sel,
   input  logic                     sw_boot,
   input  logic [PAGE_W-1:0]        sw_page,
   input  logic                     cfg_wait_we,
   input  logic [WAIT_W-1:0]        cfg_wait,
   input  logic                     ext_bus_req,
   output logic                     ext_bus_grant,
   output logic [OFFSET_W:0]        ext_addr,
   output logic [PAGE_W-2:0]        ext_dhi,
   output logic                     ext_doe,
   input  logic [BYTE_W-1:0]        ext_lane_din,
   output logic                     bsel_n,
   output logic                     rd_n,
   output logic                     ram_we,
   output logic [$clog2(WORDS)-1:0] ram_addr,
   output logic [WORD_W-1:0]        ram_wdata,
   output logic                     core_hold,
   output logic                     boot_done
);
   localparam int NB = WORD_W / BYTE_W;

   initial begin
      if (WORD_W % BYTE_W != 0) $error("word width must be a whole number of bytes");
      if (WORDS < 2) $error("at least two words required");
      if (NB * WORDS > (1 << OFFSET_W)) $error("image larger than one page");
      if (PAGE_W < 2) $error("page field needs at least two bits");
      if (WAIT_RST >= (1 << WAIT_W)) $error("reset wait value out of range");
   end

   bl_state_e         state_q;
   logic              expire;
   logic              byte_vld;
   logic              last_byte;
   logic              start;
   logic [PAGE_W-1:0] start_page;
   logic              done_q;

   assign start      = (state_q == BL_RESET && !map_sel) || (state_q == BL_IDLE && sw_boot);
   assign start_page = (state_q == BL_IDLE) ? sw_page : '0;
   assign byte_vld   = (state_q == BL_READ) && expire;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= BL_RESET;
         done_q  <= 1'b0;
      end else begin
         done_q <= (state_q == BL_FINISH);
         case (state_q)
            BL_RESET:  state_q <= map_sel ? BL_IDLE : BL_READ;
            BL_IDLE:   if (sw_boot) state_q <= BL_READ;
            BL_READ:
               if (expire) begin
                  if (last_byte)        state_q <= BL_FINISH;
                  else if (ext_bus_req) state_q <= BL_YIELD;
               end
            BL_YIELD:  if (!ext_bus_req) state_q <= BL_READ;
            BL_FINISH: state_q <= BL_IDLE;
            default:   state_q <= BL_IDLE;
         endcase
      end
   end

   bootld_wait_timer #(.WAIT_W(WAIT_W), .WAIT_RST(WAIT_RST)) u_timer (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_wait_we), .cfg_val(cfg_wait),
      .run(state_q == BL_READ), .expire(expire)
   );

   bootld_addr_gen #(.PAGE_W(PAGE_W), .OFFSET_W(OFFSET_W)) u_addr (
      .clk(clk), .rst_n(rst_n), .start(start), .start_page(start_page),
      .step(byte_vld), .ext_addr(ext_addr), .page_hi(ext_dhi)
   );

   bootld_packer #(.BYTE_W(BYTE_W), .WORD_W(WORD_W), .WORDS(WORDS)) u_pack (
      .clk(clk), .rst_n(rst_n), .clr(start), .byte_vld(byte_vld),
      .byte_in(ext_lane_din), .last_byte(last_byte), .word_we(ram_we),
      .word_addr(ram_addr), .word_data(ram_wdata)
   );

   assign rd_n          = (state_q != BL_READ);
   assign bsel_n        = (state_q != BL_READ);
   assign ext_doe       = (state_q == BL_READ);
   assign ext_bus_grant = (state_q == BL_YIELD);
   assign core_hold     = (state_q != BL_IDLE);
   assign boot_done     = done_q;

   AST_GRANT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ext_bus_grant) |-> $past(byte_vld)); // R9
   AST_ADDR_HELD_IN_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_n && $past(!rd_n) && !$past(byte_vld)) |-> $stable(ext_addr)); // R3
   AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      boot_done |-> $past(ram_we)); // R8
   AST_READ_HOLDS_CORE: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> core_hold); // R8
endmodule

// File: tb/boot_loader_test.sv
module boot_loader_test;
   localparam int WORDS = 5;
   localparam int AW    = $clog2(WORDS);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic map_sel = 1'b0, sw_boot = 1'b0, cfg_wait_we = 1'b0, ext_bus_req = 1'b0;
   logic [2:0] sw_page = '0, cfg_wait = '0;
   logic ext_bus_grant, ext_doe, bsel_n, rd_n, ram_we, core_hold, boot_done;
   logic [13:0] ext_addr;
   logic [1:0]  ext_dhi;
   logic [7:0]  ext_lane_din;
   logic [AW-1:0] ram_addr;
   logic [23:0] ram_wdata;

   int checks = 0, fails = 0, cycles = 0;
   int exp_w = 3, cur_page = 0, nbyte = 0, wexp = 0, ndone = 0, run = 0;
   logic prev_low = 1'b0, prev_we = 1'b0;
   logic [15:0] prev_ba = '0;
   logic [15:0] ba;

   always #4 clk = ~clk;

   function automatic logic [7:0] romb(int a);
      return 8'((a * 37) ^ (a >> 5) ^ 8'h3C);
   endfunction

   function automatic logic [23:0] exp_word(int pg, int n);
      int b = pg * 8192 + 3 * n;
      return {romb(b), romb(b + 1), romb(b + 2)};
   endfunction

   assign ba           = {ext_dhi, ext_addr};
   assign ext_lane_din = romb(int'(ba));

   boot_loader #(.WORDS(WORDS)) uut (
      .clk(clk), .rst_n(rst_n), .map_sel(map_sel), .sw_boot(sw_boot), .sw_page(sw_page),
      .cfg_wait_we(cfg_wait_we), .cfg_wait(cfg_wait), .ext_bus_req(ext_bus_req),
      .ext_bus_grant(ext_bus_grant), .ext_addr(ext_addr), .ext_dhi(ext_dhi),
      .ext_doe(ext_doe), .ext_lane_din(ext_lane_din), .bsel_n(bsel_n), .rd_n(rd_n),
      .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
      .core_hold(core_hold), .boot_done(boot_done)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // reference model, compared every cycle
   always @(negedge clk) begin
      if (rst_n) begin
         chk(bsel_n == rd_n, "R11 select/read strobes", int'(bsel_n), int'(rd_n));
         if (ext_bus_grant) chk(rd_n, "R9 strobe high under grant", int'(rd_n), 1);
         if (!rd_n) begin
            chk(ext_doe, "R4 page pins enabled", int'(ext_doe), 1);
            chk({ext_dhi, ext_addr[13]} == 3'(cur_page), "R4 page pin mapping",
                int'({ext_dhi, ext_addr[13]}), cur_page);
            if (prev_low && ba == prev_ba) run++;
            else begin
               if (prev_low) chk(run == exp_w + 1, "R3 byte length", run, exp_w + 1);
               chk(ba == 16'(cur_page * 8192 + nbyte), "R1 byte address", int'(ba), cur_page * 8192 + nbyte);
               nbyte++;
               run = 1;
            end
         end else if (prev_low) begin
            chk(run == exp_w + 1, "R3 byte length", run, exp_w + 1);
            run = 0;
         end
         prev_low = !rd_n;
         prev_ba  = ba;
         if (ram_we) begin
            chk(int'(ram_addr) == wexp, "R2 word address", int'(ram_addr), wexp);
            chk(ram_wdata == exp_word(cur_page, wexp), "R2 R5 word data",
                int'(ram_wdata), int'(exp_word(cur_page, wexp)));
            wexp++;
         end
         if (boot_done) begin
            ndone++;
            chk(wexp == WORDS, "R8 done after final word", wexp, WORDS);
            chk(prev_we, "R8 done follows write", int'(prev_we), 1);
            chk(!core_hold, "R8 core released", int'(core_hold), 0);
         end
         prev_we = ram_we;
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         fails++; checks++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   task automatic wait_done(input string req);
      int n = 0;
      while (!boot_done && n < 3000) begin @(negedge clk); n++; end
      chk(n < 3000, req, n, 3000);
      @(negedge clk);
   endtask

   task automatic set_wait(input int w);
      cfg_wait = 3'(w); cfg_wait_we = 1'b1;
      @(negedge clk);
      cfg_wait_we = 1'b0; exp_w = w;
   endtask

   task automatic sw_start(input int pg);
      cur_page = pg; nbyte = 0; wexp = 0;
      sw_page = 3'(pg); sw_boot = 1'b1;
      @(negedge clk);
      sw_boot = 1'b0;
   endtask

   initial begin
      int d0;
      bit ok;
      // reset state and automatic load of page 0 with the default wait
      repeat (3) @(negedge clk);
      chk(core_hold, "R8 hold in reset", int'(core_hold), 1);
      chk(rd_n && bsel_n, "R11 strobes idle in reset", int'(rd_n), 1);
      chk(!ram_we, "R2 no write in reset", int'(ram_we), 0);
      rst_n = 1'b1;
      wait_done("R6 auto load completes");
      chk(ndone == 1, "R6 one auto load", ndone, 1);
      chk(!core_hold && rd_n, "R8 idle after load", int'(core_hold), 0);

      // map select high: no load after reset
      map_sel = 1'b1; rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      ok = 1'b1;
      for (int i = 0; i < 40; i++) begin
         if (!rd_n || core_hold || ram_we) ok = 1'b0;
         @(negedge clk);
      end
      chk(ok, "R6 no load with map select high", int'(ok), 1);

      // software load, zero wait states, page 5
      set_wait(0);
      sw_start(5);
      wait_done("R7 software load completes");
      chk(wexp == WORDS, "R7 software load word count", wexp, WORDS);

      // seven wait states, page 7, bus request mid-byte, ignored boot pulse
      set_wait(7);
      d0 = ndone;
      sw_start(7);
      begin
         int n = 0;
         while (!(nbyte >= 4 && !rd_n && run == 3) && n < 500) begin @(negedge clk); n++; end
         ext_bus_req = 1'b1;
         n = 0;
         while (!ext_bus_grant && n < 50) begin @(negedge clk); n++; end
         chk(ext_bus_grant, "R9 grant arrives", int'(ext_bus_grant), 1);
         chk(n >= 4, "R9 grant waits for byte end", n, 4);
      end
      for (int i = 0; i < 6; i++) begin
         chk(ext_bus_grant && rd_n, "R9 grant held, strobes high", int'(ext_bus_grant), 1);
         @(negedge clk);
      end
      ext_bus_req = 1'b0;
      @(negedge clk);
      chk(!ext_bus_grant && !rd_n, "R9 resume after release", int'(rd_n), 0);
      sw_page = 3'd2; sw_boot = 1'b1;
      @(negedge clk);
      sw_boot = 1'b0;
      wait_done("R10 load finishes");
      chk(ndone == d0 + 1, "R10 exactly one done", ndone, d0 + 1);
      ok = 1'b1;
      for (int i = 0; i < 30; i++) begin
         if (!rd_n || core_hold) ok = 1'b0;
         @(negedge clk);
      end
      chk(ok, "R10 no second load", int'(ok), 1);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule